// File: doc/BRIEF.md
# Adaptive Sampling Rate Controller

This block sets the sampling rate of a digital voltage-regulator loop. Two clocked comparator results arrive from outside: one is high while the regulated output sits below the reference minus a margin (droop), and the other is high while it sits above the reference plus the margin (overshoot). While either one is high, the controller raises a high-speed enable that puts the oscillator into its fast mode. It then draws sampling ticks from the fast source tick stream. Once both results stay low for a programmable number of sampling periods, it returns to the slow source so that the steady state costs less power.

Both source clocks arrive as single-cycle enable strobes in the system clock domain. The selected strobe stream is divided by an integer K to produce a one-cycle sampling tick and a registered sampling clock level. Each change of source runs a break-before-make sequence. The old source is gated off, both sources stay closed for a fixed gap, and only then is the new source opened. During the gap the divider is held at zero, so the first sampling tick after a switch comes exactly K source ticks after the new gate opens.

The mode machine has five states:
- `ST_LOW`: slow source open, enable low.
- `ST_TO_HIGH`: gap before fast, enable high.
- `ST_HIGH`: fast source open, a flag is active.
- `ST_HOLD`: fast source open, flags clear, hold-off running.
- `ST_TO_LOW`: gap before slow, enable low.

It has seven transitions:
- `ST_LOW`→`ST_TO_HIGH` when a flag is seen.
- `ST_TO_HIGH`→`ST_HIGH` when the gap ends.
- `ST_HIGH`→`ST_HOLD` when both flags are clear.
- `ST_HOLD`→`ST_HIGH` when a flag returns.
- `ST_HOLD`→`ST_TO_LOW` when the hold-off count is exhausted.
- `ST_TO_LOW`→`ST_LOW` when the gap ends.
- Reset puts the machine in `ST_LOW` from any state.

Top module: `adaptive_sample_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after its release, `hs_en` is 0, the machine is in slow mode and `samp_tick` is 0.
- R2: The comparator inputs pass through SYNC_STAGES registers. With the default of 2, `hs_en` reads 1 after the third rising edge that follows a droop assertion made between edges, and it still reads 0 after the second.
- R3: An overshoot indication raises `hs_en` with the same latency as a droop indication. This holds for one lasting a single clock cycle and for droop and overshoot together.
- R4: After both flags are seen clear, `hs_en` stays 1 for exactly `holdoff` sampling ticks counted in the hold state and then falls. With `holdoff` = 0 it falls one clock after the hold state is entered.
- R5: A flag that returns during the hold-off sends the machine back to the active fast state, and `hs_en` never drops.
- R6: `samp_tick` pulses once every K ticks of the selected source, where K = `div_k`, or 1 when `div_k` is 0. Ticks of the unselected source have no effect: with K=3, a fast strobe every clock and a slow strobe every 4 clocks, the sampling period is 3 clocks in fast mode and 12 clocks in slow mode.
- R7: The two source gates are never open together. On every switch both stay closed for GAP_CYCLES clocks, with a default of 2, before the new gate opens. No `samp_tick` is produced after the first gap cycle.
- R8: The divider restarts on every mode switch. With fast strobes every clock, the first `samp_tick` after `hs_en` rises arrives exactly GAP_CYCLES+K clocks later.
- R9: `samp_clk` rises in the same cycle as each `samp_tick` and falls on the selected tick that brings the divide count to floor(K/2). With K=3 in fast mode it is high for one clock in three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_droop | input | 1 | Comparator result: output below reference minus margin |
| cmp_over | input | 1 | Comparator result: output above reference plus margin |
| slow_tick | input | 1 | One-cycle strobe of the slow source clock |
| fast_tick | input | 1 | One-cycle strobe of the fast source clock |
| div_k | input | DIV_W | Division ratio K (0 acts as 1) |
| holdoff | input | HOLD_W | Sampling ticks to wait in the hold state |
| hs_en | output | 1 | High-speed enable to the oscillator |
| samp_tick | output | 1 | One-cycle sampling strobe |
| samp_clk | output | 1 | Registered sampling clock level |

## Verification
The bound checker runs on every cycle. It checks that the two gates never overlap and that each one opens only after the other was closed on the previous cycle. It also checks that `hs_en` rises only after a flag was seen and falls only when no flag was seen, that no sampling tick appears inside a gap, that the fast gate implies the enable, and the state right after reset release. Some properties span many cycles, and only the bench scenarios can show them. These are the exact comparator-to-enable latency, the hold-off tick count, re-entry from hold, the sampling periods in both modes, the post-switch first-tick delay and the sampling clock duty pattern.

// File: rtl/adaptive_sample_ctrl_pkg.sv
package adaptive_sample_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_LOW     = 3'd0,
        ST_TO_HIGH = 3'd1,
        ST_HIGH    = 3'd2,
        ST_HOLD    = 3'd3,
        ST_TO_LOW  = 3'd4
    } asc_state_t;

endpackage

// File: rtl/asc_flag_sync.sv
module asc_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/asc_mode_fsm.sv
module asc_mode_fsm
    import adaptive_sample_ctrl_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_flag,
    input  logic              samp_tick,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              hs_en,
    output logic              gate_slow,
    output logic              gate_fast,
    output logic              div_clear
);

    localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    asc_state_t        state, state_n;
    logic [GAP_W-1:0]  gap_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              in_gap;
    logic              gap_done;

    assign in_gap   = (state == ST_TO_HIGH) || (state == ST_TO_LOW);
    assign gap_done = (gap_cnt == GAP_LAST);

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_LOW:     if (any_flag) state_n = ST_TO_HIGH;
            ST_TO_HIGH: if (gap_done) state_n = ST_HIGH;
            ST_HIGH:    if (!any_flag) state_n = ST_HOLD;
            ST_HOLD: begin
                if (any_flag)              state_n = ST_HIGH;
                else if (hold_cnt == '0)   state_n = ST_TO_LOW;
            end
            ST_TO_LOW:  if (gap_done) state_n = ST_LOW;
            default:    state_n = ST_LOW;
        endcase
    end

    // state register with gap and hold-off counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_LOW;
            gap_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            state <= state_n;
            if (state_n != state)  gap_cnt <= '0;
            else if (in_gap)       gap_cnt <= gap_cnt + 1'b1;
            if (state != ST_HOLD)
                hold_cnt <= holdoff;
            else if (samp_tick && (hold_cnt != '0))
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        hs_en     = 1'b0;
        gate_slow = 1'b0;
        gate_fast = 1'b0;
        unique case (state)
            ST_LOW:     gate_slow = 1'b1;
            ST_TO_HIGH: hs_en     = 1'b1;
            ST_HIGH: begin
                hs_en     = 1'b1;
                gate_fast = 1'b1;
            end
            ST_HOLD: begin
                hs_en     = 1'b1;
                gate_fast = 1'b1;
            end
            ST_TO_LOW:  hs_en     = 1'b0;
            default:    gate_slow = 1'b1;
        endcase
    end

    assign div_clear = in_gap;

endmodule

// File: rtl/asc_divider.sv
module asc_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] div_k,
    output logic             samp_tick,
    output logic             samp_clk
);

    logic [DIV_W-1:0] k_eff;
    logic [DIV_W-1:0] k_last;
    logic [DIV_W-1:0] k_half;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_inc;

    assign k_eff   = (div_k == '0) ? DIV_W'(1) : div_k;
    assign k_last  = k_eff - 1'b1;
    assign k_half  = k_eff >> 1;
    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            samp_tick <= 1'b0;
            samp_clk  <= 1'b0;
        end else if (clear) begin
            cnt       <= '0;
            samp_tick <= 1'b0;
            samp_clk  <= 1'b0;
        end else begin
            samp_tick <= 1'b0;
            if (tick_in) begin
                if (cnt >= k_last) begin
                    cnt       <= '0;
                    samp_tick <= 1'b1;
                    samp_clk  <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                    if (cnt_inc == k_half) samp_clk <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/adaptive_sample_ctrl.sv
module adaptive_sample_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYCLES  = 2,
    parameter int DIV_W       = 8,
    parameter int HOLD_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_droop,
    input  logic              cmp_over,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic [DIV_W-1:0]  div_k,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              hs_en,
    output logic              samp_tick,
    output logic              samp_clk
);

    logic [1:0] flags_s;
    logic       any_flag;
    logic       gate_slow;
    logic       gate_fast;
    logic       div_clear;
    logic       sel_tick;

    asc_flag_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cmp_over, cmp_droop}),
        .dout  (flags_s)
    );

    assign any_flag = |flags_s;

    asc_mode_fsm #(
        .HOLD_W     (HOLD_W),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_flag  (any_flag),
        .samp_tick (samp_tick),
        .holdoff   (holdoff),
        .hs_en     (hs_en),
        .gate_slow (gate_slow),
        .gate_fast (gate_fast),
        .div_clear (div_clear)
    );

    assign sel_tick = (slow_tick & gate_slow) | (fast_tick & gate_fast);

    asc_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (div_clear),
        .tick_in   (sel_tick),
        .div_k     (div_k),
        .samp_tick (samp_tick),
        .samp_clk  (samp_clk)
    );

endmodule

// File: rtl/adaptive_sample_ctrl_chk.sv
module adaptive_sample_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic any_flag,
    input logic gate_slow,
    input logic gate_fast,
    input logic hs_en,
    input logic samp_tick,
    input logic samp_clk
);

    logic in_gap;
    assign in_gap = !gate_slow && !gate_fast;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hs_en && gate_slow && !samp_tick));

    // R2
    hs_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(any_flag));

    // R4
    hs_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en) |-> !$past(any_flag));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_slow && gate_fast));

    // R7
    fast_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_fast) |-> !$past(gate_slow));

    // R7
    slow_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_slow) |-> !$past(gate_fast));

    // R7
    fast_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_fast |-> hs_en);

    // R8
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && $past(in_gap)) |-> !samp_tick);

    // R9
    clk_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_tick |-> samp_clk);

endmodule

bind adaptive_sample_ctrl adaptive_sample_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_flag  (any_flag),
    .gate_slow (gate_slow),
    .gate_fast (gate_fast),
    .hs_en     (hs_en),
    .samp_tick (samp_tick),
    .samp_clk  (samp_clk)
);

// File: tb/adaptive_sample_ctrl_bench.sv
module adaptive_sample_ctrl_bench;

    localparam int GAP = 2;
    localparam int K   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_droop = 1'b0;
    logic       cmp_over = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b1;
    logic [7:0] div_k = 8'(K);
    logic [7:0] holdoff = 8'd2;
    logic       hs_en, samp_tick, samp_clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adaptive_sample_ctrl u_adaptive_sample_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_droop (cmp_droop),
        .cmp_over  (cmp_over),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .div_k     (div_k),
        .holdoff   (holdoff),
        .hs_en     (hs_en),
        .samp_tick (samp_tick),
        .samp_clk  (samp_clk)
    );

    // slow strobe: one cycle in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            slow_tick = (ph == 0);
        end
    end

    typedef struct packed {
        logic       lo;
        logic       hi;
        logic [7:0] wait_n;
        logic       exp_hs;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{lo:1'b0, hi:1'b0, wait_n:8'd20, exp_hs:1'b0},
        '{lo:1'b1, hi:1'b0, wait_n:8'd20, exp_hs:1'b1},
        '{lo:1'b0, hi:1'b0, wait_n:8'd40, exp_hs:1'b0},
        '{lo:1'b0, hi:1'b1, wait_n:8'd20, exp_hs:1'b1},
        '{lo:1'b1, hi:1'b1, wait_n:8'd20, exp_hs:1'b1},
        '{lo:1'b0, hi:1'b0, wait_n:8'd40, exp_hs:1'b0},
        '{lo:1'b0, hi:1'b1, wait_n:8'd20, exp_hs:1'b1},
        '{lo:1'b0, hi:1'b0, wait_n:8'd40, exp_hs:1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // negedges until samp_tick is seen, bounded
    task automatic cycles_to_tick(output int n);
        n = 0;
        while (!samp_tick && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        int ok;
        // R1: reset state
        step(4);
        check("R1 hs_en in reset", int'(hs_en), 0);
        check("R1 samp_tick in reset", int'(samp_tick), 0);
        rst_n = 1'b1;
        step(1);
        check("R1 hs_en after release", int'(hs_en), 0);
        check("R1 samp_tick after release", int'(samp_tick), 0);
        step(30);

        // R2/R3/R4: vector table
        foreach (VECS[i]) begin
            cmp_droop = VECS[i].lo;
            cmp_over  = VECS[i].hi;
            step(int'(VECS[i].wait_n));
            check($sformatf("R3 table entry %0d hs_en", i), int'(hs_en), int'(VECS[i].exp_hs));
        end

        // R6: slow-mode period
        cycles_to_tick(n);
        step(1);
        cycles_to_tick(n);
        check("R6 slow period", n + 1, 4 * K);

        // R2: droop latency
        cmp_droop = 1'b1;
        step(2);
        check("R2 hs_en before latency", int'(hs_en), 0);
        step(1);
        check("R2 hs_en at latency", int'(hs_en), 1);

        // R8: first tick after switch
        cycles_to_tick(n);
        check("R8 first tick delay", n, GAP + K);

        // R9: samp_clk shape with K=3 in fast mode
        check("R9 samp_clk with tick", int'(samp_clk), 1);
        step(1);
        check("R9 samp_clk falls", int'(samp_clk), 0);
        step(1);
        check("R9 samp_clk stays low", int'(samp_clk), 0);
        step(1);
        check("R9 samp_clk next rise", int'(samp_clk), 1);

        // R6: fast-mode period
        step(1);
        cycles_to_tick(n);
        check("R6 fast period", n + 1, K);

        // R4: hold-off of 2 ticks
        cmp_droop = 1'b0;
        step(3);
        check("R4 hs_en on hold entry", int'(hs_en), 1);
        n = 0;
        ok = 0;
        while (hs_en && ok < 1000) begin
            if (samp_tick) n++;
            @(negedge clk);
            ok++;
        end
        check("R4 ticks during hold-off", n, 2);

        // R7: return to slow, first tick window
        cycles_to_tick(n);
        check_range("R7 first slow tick after gap", n, GAP + 4 * (K - 1) + 1, GAP + 4 * (K - 1) + 4);
        step(20);

        // R5: flag returns during hold-off
        holdoff = 8'd4;
        cmp_droop = 1'b1;
        step(15);
        cmp_droop = 1'b0;
        step(4);
        cmp_over = 1'b1;
        ok = 1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (!hs_en) ok = 0;
        end
        check("R5 hs_en kept through re-entry", ok, 1);

        // R6: div_k of 0 acts as 1
        div_k = 8'd0;
        step(5);
        ok = 1;
        for (int c = 0; c < 4; c++) begin
            if (!samp_tick) ok = 0;
            @(negedge clk);
        end
        check("R6 div_k zero ticks every cycle", ok, 1);
        div_k = 8'(K);

        // R4: zero hold-off
        holdoff = 8'd0;
        cmp_over = 1'b0;
        step(3);
        check("R4 zero hold-off on entry", int'(hs_en), 1);
        step(1);
        check("R4 zero hold-off drop", int'(hs_en), 0);
        step(20);

        // R3: single-cycle overshoot pulse
        cmp_over = 1'b1;
        step(1);
        cmp_over = 1'b0;
        step(2);
        check("R3 short overshoot pulse", int'(hs_en), 1);
        cmp_droop = 1'b1;
        step(20);

        // R1: reset while in fast mode
        rst_n = 1'b0;
        step(1);
        check("R1 hs_en after mid-run reset", int'(hs_en), 0);
        check("R1 samp_tick after mid-run reset", int'(samp_tick), 0);
        cmp_droop = 1'b0;
        rst_n = 1'b1;
        step(5);
        check("R1 stays slow with no flag", int'(hs_en), 0);

        finish_run();
    end

endmodule